// File: doc/BRIEF.md
# Queue-Triggering Periodic Interval Timer

This block paces two conversion queues of a queued ADC controller. A single free-running counter advances on a prescaled clock enable. Each time a chosen counter bit is about to toggle, the block issues a one-cycle trigger to every queue whose operating mode currently relies on the timer. Each queue presents a mode field that combines a kind (off, externally started, periodic, or one-shot interval) with a period selector. In one-shot interval mode, a per-queue arm input enables a single trigger.

Most of the logic decides when the counter must not run. The counter is held at zero in these cases:
- no queue needs the counter;
- a reset or stop request is present;
- a freeze request is in effect.

It receives a one-cycle clear when it wraps and when a queue moves from one timer setting to another. A queue-2 setting change is ignored while queue 1 is actively timing. A freeze request takes hold at once, except when a trigger has been issued and the resulting conversion is still busy. In that case the counter runs on until the conversion finishes and is then cleared.

Top module: `queue_interval_timer`

## Requirements
- R1: A mode field is `{kind[1:0], sel[SEL_W-1:0]}`, with kind 2'b00 off, 2'b01 externally started, 2'b10 periodic and 2'b11 one-shot interval. The counter is held at zero, and no trigger is issued, while no queue is active. A queue is active when it is periodic, or when it is one-shot with its arm input high and its shot not yet taken.
- R2: The period is 2^e ticks of `tick_en`, where e = MIN_EXP + min(sel, MAX_EXP-MIN_EXP). After a release from hold at a constant tick, the first trigger comes 2^e ticks later, and the following triggers repeat every 2^e ticks. Cycles without `tick_en` do not advance the counter.
- R3: A trigger is a pulse on `qN_trig` one cycle wide, sent to every active queue. The period comes from queue 1's selector when queue 1 is active, and from queue 2's selector otherwise.
- R4: In one-shot mode, a queue receives exactly one trigger per arming. After the shot, the timer stops unless another queue is active. Lowering and raising the arm input re-arms the queue. A one-shot queue whose arm input is low keeps the timer stopped.
- R5: While `master_rst` or `stop_req` is high, the counter is held at zero and no trigger is issued. After the request is released, timing restarts from zero.
- R6: When the counter wraps from all ones, it is cleared. The trigger spacing is not disturbed across the wrap.
- R7: A change of queue 1's mode field from one timer setting (kind 2'b10 or 2'b11) to a different timer setting clears the counter for one cycle. The same applies to queue 2 when queue 1 is not active. After the clear cycle, the next trigger follows 2^e ticks later.
- R8: A change of queue 2's timer setting to another timer setting while queue 1 is active does not clear the counter.
- R9: When `freeze_req` is raised and either no trigger has been issued since the counter last started or `conv_busy` is low, the counter is held at zero from the next edge.
- R10: When `freeze_req` is raised after a trigger while `conv_busy` is high, the counter keeps counting and no triggers are issued. Once `conv_busy` falls with the freeze still present, the counter is held at zero.
- R11: When `freeze_req` falls, counting restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| master_rst | input | 1 | Synchronous master reset, holds the timer at zero |
| stop_req | input | 1 | Low-power stop request, holds the timer at zero |
| freeze_req | input | 1 | Debug freeze request |
| conv_busy | input | 1 | A conversion is in progress |
| tick_en | input | 1 | Prescaled conversion clock enable |
| q1_mode | input | SEL_W+2 | Queue 1 mode field {kind, sel} |
| q2_mode | input | SEL_W+2 | Queue 2 mode field {kind, sel} |
| q1_ss_en | input | 1 | Queue 1 one-shot arm |
| q2_ss_en | input | 1 | Queue 2 one-shot arm |
| q1_trig | output | 1 | Queue 1 trigger pulse |
| q2_trig | output | 1 | Queue 2 trigger pulse |

## Verification
The trigger is registered, so it is visible at the first falling edge after the rising edge on which the counter reaches 2^e. When inputs are driven at a falling edge with `tick_en` high, the first trigger of a fresh start is therefore due exactly 2^e rising edges later. A counter clear caused by a mode change takes one extra edge, so the trigger is due 2^e+1 edges later. The bench counts rising edges from the stimulus and samples each trigger at the falling edge that follows. Every expected distance is derived from this rule: 9, 12, 26 or 32 edges in the mode-change and freeze scenarios, and 16 edges when the tick comes on alternate cycles.

// File: rtl/qit_pkg.sv
package qit_pkg;

  typedef enum logic [1:0] {
    KIND_OFF      = 2'b00,
    KIND_EXT      = 2'b01,
    KIND_PERIODIC = 2'b10,
    KIND_SINGLE   = 2'b11
  } kind_e;

  // A kind uses the shared counter when its upper bit is set.
  function automatic logic kind_is_timer(input logic [1:0] k);
    return k[1];
  endfunction

  // Exponent of the trigger period, selector clamped to the legal span.
  function automatic logic [5:0] period_exp(input logic [7:0] sel,
                                            input int unsigned min_e,
                                            input int unsigned max_e);
    int unsigned s;
    s = 32'(sel);
    if (s > max_e - min_e) s = max_e - min_e;
    return 6'(min_e + s);
  endfunction

  // True when all bits below position e are ones (bit e toggles next tick).
  function automatic logic low_bits_full(input logic [31:0] v, input logic [5:0] e);
    logic [31:0] m;
    m = (32'd1 << e) - 32'd1;
    return (v & m) == m;
  endfunction

endpackage

// File: rtl/qit_counter.sv
module qit_counter
  import qit_pkg::*;
#(
  parameter int CW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold,
  input  logic          pulse,
  input  logic          tick_en,
  input  logic          freeze_req,
  input  logic [5:0]    exp_sel,
  output logic [CW-1:0] cnt,
  output logic          fire,
  output logic          roll,
  output logic          trig_seen
);

  logic run;

  assign run  = tick_en & ~hold & ~pulse;
  assign fire = run & ~freeze_req & low_bits_full(32'(cnt), exp_sel);
  assign roll = run & (&cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      trig_seen <= 1'b0;
    end else begin
      if (hold | pulse | roll) cnt <= '0;
      else if (run)            cnt <= cnt + 1'b1;

      if (hold | pulse) trig_seen <= 1'b0;
      else if (fire)    trig_seen <= 1'b1;
    end
  end

  // R1
  held_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (cnt == '0));

  // R6
  roll_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    roll |=> (cnt == '0));

  // R2
  cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !hold && !pulse) |=> $stable(cnt));

endmodule

// File: rtl/qit_queue_slot.sv
module qit_queue_slot
  import qit_pkg::*;
#(
  parameter int SEL_W = 4,
  localparam int MW   = SEL_W + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [MW-1:0] mode,
  input  logic          ss_en,
  input  logic          fire,
  output logic          active,
  output logic          trig
);

  kind_e kind;
  logic  spent;
  logic  shot;

  assign kind   = kind_e'(mode[MW-1:MW-2]);
  assign active = (kind == KIND_PERIODIC) | ((kind == KIND_SINGLE) & ss_en & ~spent);
  assign shot   = fire & active & (kind == KIND_SINGLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spent <= 1'b0;
      trig  <= 1'b0;
    end else begin
      trig <= fire & active;
      if (clr | ~ss_en | (kind != KIND_SINGLE)) spent <= 1'b0;
      else if (shot)                            spent <= 1'b1;
    end
  end

  // R3
  trig_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> !trig);

  // R4
  ss_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shot |=> ((kind != KIND_SINGLE) || !active));

endmodule

// File: rtl/qit_hold_ctl.sv
module qit_hold_ctl
  import qit_pkg::*;
#(
  parameter int MW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          master_rst,
  input  logic          stop_req,
  input  logic          freeze_req,
  input  logic          conv_busy,
  input  logic          trig_seen,
  input  logic          any_active,
  input  logic          q1_active,
  input  logic [MW-1:0] q1_mode,
  input  logic [MW-1:0] q2_mode,
  output logic          hold,
  output logic          pulse
);

  logic [MW-1:0] prev1, prev2;
  logic          frz_held;
  logic          frz_now;
  logic          chg1, chg2;

  assign chg1 = kind_is_timer(prev1[MW-1:MW-2]) & kind_is_timer(q1_mode[MW-1:MW-2])
              & (prev1 != q1_mode);
  assign chg2 = kind_is_timer(prev2[MW-1:MW-2]) & kind_is_timer(q2_mode[MW-1:MW-2])
              & (prev2 != q2_mode);
  assign pulse = chg1 | (chg2 & ~q1_active);

  // Freeze waits only for a conversion launched by an issued trigger.
  assign frz_now = freeze_req & (frz_held | ~(conv_busy & trig_seen));
  assign hold    = master_rst | stop_req | ~any_active | frz_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev1    <= '0;
      prev2    <= '0;
      frz_held <= 1'b0;
    end else begin
      prev1    <= q1_mode;
      prev2    <= q2_mode;
      frz_held <= frz_now;
    end
  end

  // R10
  frz_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frz_held && freeze_req) |-> hold);

endmodule

// File: rtl/queue_interval_timer.sv
module queue_interval_timer
  import qit_pkg::*;
#(
  parameter int MIN_EXP = 7,
  parameter int MAX_EXP = 17,
  parameter int SEL_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               master_rst,
  input  logic               stop_req,
  input  logic               freeze_req,
  input  logic               conv_busy,
  input  logic               tick_en,
  input  logic [SEL_W+1:0]   q1_mode,
  input  logic [SEL_W+1:0]   q2_mode,
  input  logic               q1_ss_en,
  input  logic               q2_ss_en,
  output logic               q1_trig,
  output logic               q2_trig
);

  localparam int MW = SEL_W + 2;
  localparam int CW = MAX_EXP + 1;
  localparam int NQ = 2;

  logic [MW-1:0] mode_v [NQ];
  logic          en_v   [NQ];
  logic          act_v  [NQ];
  logic          trg_v  [NQ];

  logic          hold, pulse, fire, roll, trig_seen, any_active;
  logic [CW-1:0] cnt;
  logic [5:0]    exp_sel;

  assign mode_v[0] = q1_mode;
  assign mode_v[1] = q2_mode;
  assign en_v[0]   = q1_ss_en;
  assign en_v[1]   = q2_ss_en;
  assign q1_trig   = trg_v[0];
  assign q2_trig   = trg_v[1];

  assign any_active = act_v[0] | act_v[1];
  assign exp_sel    = act_v[0] ? period_exp(8'(mode_v[0][SEL_W-1:0]), MIN_EXP, MAX_EXP)
                               : period_exp(8'(mode_v[1][SEL_W-1:0]), MIN_EXP, MAX_EXP);

  for (genvar g = 0; g < NQ; g++) begin : g_slot
    qit_queue_slot #(.SEL_W(SEL_W)) u_slot (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (master_rst | stop_req),
      .mode   (mode_v[g]),
      .ss_en  (en_v[g]),
      .fire   (fire),
      .active (act_v[g]),
      .trig   (trg_v[g])
    );
  end

  qit_hold_ctl #(.MW(MW)) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .master_rst (master_rst),
    .stop_req   (stop_req),
    .freeze_req (freeze_req),
    .conv_busy  (conv_busy),
    .trig_seen  (trig_seen),
    .any_active (any_active),
    .q1_active  (act_v[0]),
    .q1_mode    (q1_mode),
    .q2_mode    (q2_mode),
    .hold       (hold),
    .pulse      (pulse)
  );

  qit_counter #(.CW(CW)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .hold       (hold),
    .pulse      (pulse),
    .tick_en    (tick_en),
    .freeze_req (freeze_req),
    .exp_sel    (exp_sel),
    .cnt        (cnt),
    .fire       (fire),
    .roll       (roll),
    .trig_seen  (trig_seen)
  );

  // R5
  clr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (master_rst || stop_req) |=> (!q1_trig && !q2_trig && cnt == '0));

  // R9
  frz_immediate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze_req && !conv_busy) |=> (cnt == '0));

  // R3
  route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && act_v[0] && act_v[1]) |=> (q1_trig && q2_trig));

endmodule

// File: tb/tb_queue_interval_timer.sv
module tb_queue_interval_timer;
  import qit_pkg::*;

  localparam int SEL_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic master_rst = 1'b0, stop_req = 1'b0, freeze_req = 1'b0, conv_busy = 1'b0;
  logic tick_en = 1'b1;
  logic tick_alt = 1'b0;
  logic [SEL_W+1:0] q1_mode = '0, q2_mode = '0;
  logic q1_ss_en = 1'b0, q2_ss_en = 1'b0;
  logic q1_trig, q2_trig;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  always @(negedge clk) tick_en <= tick_alt ? ~tick_en : 1'b1;

  queue_interval_timer #(.MIN_EXP(3), .MAX_EXP(6), .SEL_W(SEL_W)) dut (
    .clk(clk), .rst_n(rst_n), .master_rst(master_rst), .stop_req(stop_req),
    .freeze_req(freeze_req), .conv_busy(conv_busy), .tick_en(tick_en),
    .q1_mode(q1_mode), .q2_mode(q2_mode), .q1_ss_en(q1_ss_en), .q2_ss_en(q2_ss_en),
    .q1_trig(q1_trig), .q2_trig(q2_trig)
  );

  function automatic logic [SEL_W+1:0] md(input kind_e k, input int sel);
    return {k, SEL_W'(sel)};
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_trig(input int q, input int lim, output int n);
    n = -1;
    for (int i = 1; i <= lim; i++) begin
      @(posedge clk);
      @(negedge clk);
      if ((q == 1) ? q1_trig : q2_trig) begin
        n = i;
        break;
      end
    end
  endtask

  task automatic count_trigs(input int q, input int cyc, output int n);
    n = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if ((q == 1) ? q1_trig : q2_trig) n++;
    end
  endtask

  task automatic idle();
    q1_mode = '0; q2_mode = '0; q1_ss_en = 0; q2_ss_en = 0;
    master_rst = 0; stop_req = 0; freeze_req = 0; conv_busy = 0; tick_alt = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 reset q1_trig", q1_trig, 0);
    check("R1 reset q2_trig", q2_trig, 0);
  endtask

  task automatic t_no_timer();
    int n;
    idle();
    q1_mode = md(KIND_EXT, 0); q2_mode = md(KIND_OFF, 0);
    count_trigs(1, 150, n); check("R1 no timer mode q1", n, 0);
    q1_mode = md(KIND_SINGLE, 0); q2_mode = md(KIND_EXT, 0);
    count_trigs(1, 100, n); check("R4 one-shot unarmed", n, 0);
  endtask

  task automatic t_period();
    int n;
    idle();
    q1_mode = md(KIND_PERIODIC, 0);
    wait_trig(1, 100, n); check("R2 first trigger sel0", n, 8);
    wait_trig(1, 100, n); check("R2 repeat sel0", n, 8);
    idle();
    q1_mode = md(KIND_PERIODIC, 2);
    wait_trig(1, 100, n); check("R2 first trigger sel2", n, 32);
    idle();
    q1_mode = md(KIND_PERIODIC, 15);
    wait_trig(1, 200, n); check("R2 clamped selector", n, 64);
    idle();
    tick_alt = 1;
    q1_mode = md(KIND_PERIODIC, 0);
    wait_trig(1, 100, n);
    wait_trig(1, 100, n); check("R2 half-rate tick", n, 16);
  endtask

  task automatic t_route();
    int n;
    idle();
    q1_mode = md(KIND_PERIODIC, 0); q2_mode = md(KIND_PERIODIC, 2);
    wait_trig(2, 100, n); check("R3 period from q1", n, 8);
    check("R3 q1 fires with q2", q1_trig, 1);
    @(negedge clk);
    check("R3 pulse one cycle", q2_trig, 0);
    idle();
    q1_mode = md(KIND_EXT, 0); q2_mode = md(KIND_PERIODIC, 0);
    wait_trig(2, 100, n); check("R3 q2 alone", n, 8);
    check("R3 q1 not routed", q1_trig, 0);
  endtask

  task automatic t_single();
    int n;
    idle();
    q2_mode = md(KIND_SINGLE, 0); q2_ss_en = 1;
    wait_trig(2, 100, n); check("R4 one-shot fires", n, 8);
    count_trigs(2, 60, n); check("R4 only one shot", n, 0);
    q2_ss_en = 0;
    repeat (2) @(negedge clk);
    q2_ss_en = 1;
    wait_trig(2, 100, n); check("R4 re-armed shot", n, 8);
  endtask

  task automatic t_roll();
    int n;
    idle();
    q1_mode = md(KIND_PERIODIC, 3);
    wait_trig(1, 200, n); check("R6 first 64", n, 64);
    for (int k = 0; k < 3; k++) begin
      wait_trig(1, 200, n); check("R6 spacing across wrap", n, 64);
    end
  endtask

  task automatic t_change();
    int n;
    idle();
    q1_mode = md(KIND_PERIODIC, 1);
    wait_trig(1, 100, n); check("R7 q1 base", n, 16);
    repeat (10) @(negedge clk);
    q1_mode = md(KIND_PERIODIC, 0);
    wait_trig(1, 100, n); check("R7 q1 change clears", n, 9);
    idle();
    q1_mode = md(KIND_EXT, 0); q2_mode = md(KIND_PERIODIC, 1);
    wait_trig(2, 100, n);
    repeat (4) @(negedge clk);
    q2_mode = md(KIND_PERIODIC, 0);
    wait_trig(2, 100, n); check("R7 q2 change clears", n, 9);
    idle();
    q1_mode = md(KIND_PERIODIC, 1); q2_mode = md(KIND_PERIODIC, 0);
    wait_trig(1, 100, n);
    repeat (4) @(negedge clk);
    q2_mode = md(KIND_PERIODIC, 2);
    wait_trig(1, 100, n); check("R8 q2 change ignored", n, 12);
  endtask

  task automatic t_freeze();
    int n;
    idle();
    q1_mode = md(KIND_PERIODIC, 0);
    repeat (5) @(negedge clk);
    freeze_req = 1;
    count_trigs(1, 30, n); check("R9 freeze holds at once", n, 0);
    freeze_req = 0;
    wait_trig(1, 100, n); check("R11 restart from zero", n, 8);
    idle();
    q1_mode = md(KIND_PERIODIC, 2);
    wait_trig(1, 100, n);
    conv_busy = 1; freeze_req = 1;
    repeat (6) @(negedge clk);
    freeze_req = 0;
    wait_trig(1, 100, n); check("R10 count runs during busy", n, 26);
    conv_busy = 1; freeze_req = 1;
    repeat (3) @(negedge clk);
    conv_busy = 0;
    repeat (5) @(negedge clk);
    freeze_req = 0;
    wait_trig(1, 100, n); check("R10 held after busy ends", n, 32);
  endtask

  task automatic t_stop();
    int n;
    idle();
    q1_mode = md(KIND_PERIODIC, 0);
    wait_trig(1, 100, n);
    stop_req = 1;
    count_trigs(1, 30, n); check("R5 stop silences", n, 0);
    stop_req = 0;
    wait_trig(1, 100, n); check("R5 stop restart", n, 8);
    master_rst = 1;
    count_trigs(1, 30, n); check("R5 master silences", n, 0);
    master_rst = 0;
    wait_trig(1, 100, n); check("R5 master restart", n, 8);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_no_timer();
    t_period();
    t_route();
    t_single();
    t_roll();
    t_change();
    t_freeze();
    t_stop();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      vectors++;
      miscompares++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule